// File: doc/BRIEF.md
# Programmable Countdown Timer with Periodic and One-Shot Modes

This block is one countdown timer with a two-word register window. Software writes a load word that holds three fields: a run flag, a repeat flag and a start count. The count then steps down once on each cycle in which the free-running `tick` input is high. The load word uses an off-by-one encoding. A stored count of N gives an expiry on the (N+1)th qualifying tick after the write.

On expiry the timer sets a level interrupt flag. The flag stays set until software writes a one to the clear bit of the second word. In repeat mode the count reloads from the stored value and keeps running. In single-shot mode the run flag drops and the timer stops. Writing a load word with the run flag low, such as an all-zero word, halts the timer.

Register access completes in the cycle it is presented, so the bus has no valid/ready handshake and no back-pressure. A write is a one-cycle `bus_we` strobe, and read data is a combinational function of `bus_addr`.

Top module: `tmr_unit`

## Requirements
- R1: After reset `irq` is low and both words read as zero.
- R2: Address bit 2 selects the word, and the other address bits are ignored. The load word is at byte offset 0x0. In the load word, bit 31 is the run flag, bit 30 is the repeat flag and bits 28:0 are the count. A read returns the stored fields, with bit 29 always reading as zero. Bit 29 of a write is dropped.
- R3: A load write with bit 31 set makes `irq` rise after exactly N+1 tick cycles, counted from the write edge, where N is the written count. N=0 gives one tick.
- R4: The count changes only on cycles where `tick` is high. With `tick` held low, a running timer never expires.
- R5: In single-shot mode (bit 30 clear), an expiry clears the stored run flag. No further expiry follows.
- R6: In repeat mode (bit 30 set), the timer expires every N+1 ticks and the run flag stays set.
- R7: A load write while the timer runs discards the remaining count and restarts from the new value. A tick in the same cycle as the write is ignored.
- R8: A load write with bit 31 clear (for example, all zeros) stops the timer, and no expiry follows.
- R9: `irq` is a level that stays high until a write to byte offset 0x4 with bit 30 set. Writes to 0x4 with bit 30 clear have no effect, and a write to 0x4 leaves the load word unchanged.
- R10: When an expiry and a clear write fall in the same cycle, `irq` stays set.
- R11: Reading byte offset 0x4 returns the pending flag in bit 30 and zeros in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable; the count steps only when high |
| bus_we | input | 1 | One-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address within the timer window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, sticky until cleared |

## Verification
A write sampled at edge k changes the stored fields, the count and the clear state at that same edge. The bench therefore reads back or checks `irq` at the following falling edge.

Expiry is measured in ticks rather than cycles. A monitor counts the tick-high edges since the last load write or the last expiry. At each rising edge it samples, and 1 ns after that edge it looks for an `irq` rise. It compares the count against the N+1 value that the driver queued when it issued the write. Any rise with no queued value counts as a failure.

The same-cycle clear case places the clear strobe at edge k+4 after a load of 3. With a tick every cycle, that is exactly the expiry edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Byte-address bit that picks one of the two words in the window.
  localparam int WORD_SEL_BIT = 2;

  typedef enum logic {
    SEL_LOAD = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 29,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              oneshot_done,
  input  logic              irq_flag,
  output logic              cfg_en,
  output logic              cfg_per,
  output logic [CNT_W-1:0]  cfg_val,
  output logic              load_wr,
  output logic              clr_wr,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int RUN_BIT = DATA_W - 1;
  localparam int REP_BIT = DATA_W - 2;
  localparam int CLR_BIT = DATA_W - 2;
  localparam logic [DATA_W-1:0] USED_MASK =
    (DATA_W'(1) << RUN_BIT) | (DATA_W'(1) << REP_BIT) | ((DATA_W'(1) << CNT_W) - DATA_W'(1));
  localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'(1) << WORD_SEL_BIT;

  reg_sel_e sel;
  assign sel     = reg_sel_e'(bus_addr[WORD_SEL_BIT]);
  assign load_wr = bus_we && (sel == SEL_LOAD);
  assign clr_wr  = bus_we && (sel == SEL_CTRL) && bus_wdata[CLR_BIT];

  // Address and data bits with no function in this window.
  logic unused_bits;
  assign unused_bits = ^{bus_addr & ~SEL_MASK, bus_wdata & ~USED_MASK};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en  <= 1'b0;
      cfg_per <= 1'b0;
      cfg_val <= '0;
    end else if (load_wr) begin
      cfg_en  <= bus_wdata[RUN_BIT];
      cfg_per <= bus_wdata[REP_BIT];
      cfg_val <= bus_wdata[CNT_W-1:0];
    end else if (oneshot_done) begin
      cfg_en  <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel == SEL_LOAD) begin
      bus_rdata[RUN_BIT]   = cfg_en;
      bus_rdata[REP_BIT]   = cfg_per;
      bus_rdata[CNT_W-1:0] = cfg_val;
    end else begin
      bus_rdata[CLR_BIT] = irq_flag;
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             repeat_mode,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expire,
  output logic [CNT_W-1:0] cnt_q
);

  logic at_zero;
  assign at_zero = (cnt_q == '0);
  // A load write takes priority over a tick in the same cycle.
  assign expire  = run && tick && !load_wr && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_wr) begin
      cnt_q <= load_val;
    end else if (run && tick) begin
      if (at_zero) begin
        cnt_q <= repeat_mode ? reload_val : '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);

  // Set wins over clear when both land in one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set_evt) begin
      flag <= 1'b1;
    end else if (clr_evt) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 29,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic             cfg_en;
  logic             cfg_per;
  logic [CNT_W-1:0] cfg_val;
  logic             load_wr;
  logic             clr_wr;
  logic             expire;
  logic [CNT_W-1:0] cnt_q;
  logic             oneshot_done;

  assign oneshot_done = expire && !cfg_per;

  tmr_regs #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .oneshot_done(oneshot_done),
    .irq_flag    (irq),
    .cfg_en      (cfg_en),
    .cfg_per     (cfg_per),
    .cfg_val     (cfg_val),
    .load_wr     (load_wr),
    .clr_wr      (clr_wr),
    .bus_rdata   (bus_rdata)
  );

  tmr_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load_wr    (load_wr),
    .load_val   (bus_wdata[CNT_W-1:0]),
    .run        (cfg_en),
    .repeat_mode(cfg_per),
    .reload_val (cfg_val),
    .expire     (expire),
    .cnt_q      (cnt_q)
  );

  tmr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(expire),
    .clr_evt(clr_wr),
    .flag   (irq)
  );

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             load_wr,
  input logic             clr_wr,
  input logic             irq,
  input logic             expire,
  input logic             cfg_en,
  input logic             cfg_per,
  input logic [CNT_W-1:0] cnt
);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  // R10
  expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cfg_per && !load_wr) |=> !cfg_en);

  // R6
  repeat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cfg_per && !load_wr) |=> cfg_en);

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_wr) |=> $stable(cnt));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !expire);

endmodule

bind tmr_unit tmr_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .load_wr(load_wr),
  .clr_wr (clr_wr),
  .irq    (irq),
  .expire (expire),
  .cfg_en (cfg_en),
  .cfg_per(cfg_per),
  .cnt    (cnt_q)
);

// File: tb/tmr_unit_tb.sv
`timescale 1ns/1ps
module tmr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int tick_on = 0;
  int tick_every = 1;
  int cyc = 0;

  int exp_q[$];

  always #2.5 clk = ~clk;

  tmr_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Timebase generator
  always @(negedge clk) begin
    cyc++;
    tick = (tick_on != 0) && (cyc % tick_every == 0);
  end

  // Scoreboard monitor: ticks between a load (or the previous expiry) and each irq rise
  int   tsince = 0;
  logic irq_prev = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) tsince = 0;
    else if (bus_we && !bus_addr[2]) tsince = 0;
    else if (tick) tsince++;
    #1;
    if (rst_n && irq && !irq_prev) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected expiry", 32'(tsince), 32'hFFFF_FFFF);
      end else begin
        chk("R3 ticks to expiry", 32'(tsince), 32'(exp_q.pop_front()));
      end
      tsince = 0;
    end
    irq_prev = irq;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wait_irq(input string req, input int lim);
    for (int i = 0; i < lim && !irq; i++) @(negedge clk);
    chk(req, 32'(irq), 32'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'd0);
    rd("R1 load word", 3'h0, 32'h0);
    rd("R1 ctrl word", 3'h4, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 field read-back, bit 29 dropped, low address bits ignored
    wr(3'h0, 32'h5FFF_FFFF);
    rd("R2 read-back", 3'h0, 32'h5FFF_FFFF);
    wr(3'h3, 32'h2000_0005);
    rd("R2 bit29 dropped", 3'h1, 32'h0000_0005);
    wr(3'h0, 32'h0);

    // R3 / R5 single shot, N=4, tick every cycle
    tick_every = 1; tick_on = 1;
    exp_q.push_back(5);
    wr(3'h0, 32'h8000_0004);
    wait_irq("R3 single shot fires", 40);
    rd("R5 run flag cleared", 3'h0, 32'h0000_0004);
    rd("R11 ctrl shows pending", 3'h4, 32'h4000_0000);
    repeat (20) @(negedge clk);
    chk("R9 irq held", 32'(irq), 32'd1);
    wr(3'h4, 32'hBFFF_FFFF);
    chk("R9 write without clear bit", 32'(irq), 32'd1);
    rd("R9 load word untouched by ctrl write", 3'h0, 32'h0000_0004);
    wr(3'h4, 32'h4000_0000);
    chk("R9 clear", 32'(irq), 32'd0);
    repeat (20) @(negedge clk);
    chk("R5 no second expiry", 32'(irq), 32'd0);

    // R3 N=0
    exp_q.push_back(1);
    wr(3'h0, 32'h8000_0000);
    wait_irq("R3 N=0 fires", 10);
    wr(3'h4, 32'h4000_0000);

    // R6 repeat mode, N=2, tick every 4 cycles
    tick_every = 4;
    for (int i = 0; i < 3; i++) exp_q.push_back(3);
    wr(3'h0, 32'hC000_0002);
    for (int i = 0; i < 3; i++) begin
      wait_irq("R6 periodic expiry", 60);
      wr(3'h4, 32'h4000_0000);
    end
    rd("R6 run flag kept", 3'h0, 32'hC000_0002);
    // R8 stop with zero word
    wr(3'h0, 32'h0);
    rd("R8 stopped word", 3'h0, 32'h0);
    repeat (60) @(negedge clk);
    chk("R8 no expiry after stop", 32'(irq), 32'd0);

    // R4 tick gating
    tick_on = 0; tick_every = 1;
    exp_q.push_back(2);
    wr(3'h0, 32'h8000_0001);
    repeat (40) @(negedge clk);
    chk("R4 no expiry without tick", 32'(irq), 32'd0);
    tick_on = 1;
    wait_irq("R4 expiry once ticks run", 20);
    wr(3'h4, 32'h4000_0000);

    // R7 restart discards progress
    exp_q.push_back(4);
    wr(3'h0, 32'h8000_000A);
    repeat (5) @(negedge clk);
    wr(3'h0, 32'h8000_0003);
    wait_irq("R7 restart expiry", 20);

    // R10 clear coincides with expiry while pending
    wr(3'h0, 32'h8000_0003);
    repeat (3) @(negedge clk);
    wr(3'h4, 32'h4000_0000);
    chk("R10 expiry beats clear", 32'(irq), 32'd1);
    rd("R10 single shot done", 3'h0, 32'h0000_0003);
    wr(3'h4, 32'h4000_0000);
    chk("R10 later clear works", 32'(irq), 32'd0);
    rd("R11 ctrl cleared", 3'h4, 32'h0);

    repeat (10) @(negedge clk);
    chk("R3 all expected expiries seen", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule